// File: doc/BRIEF.md
# Banked GPIO Data and Direction Registers

This block holds the data and direction state for a set of general-purpose I/O banks of 32 pins each. All banks sit in one shared register window. Bank `b` owns a group of five word registers that starts at byte address 0x10 + 0x28*b. Pin number `p` belongs to bank `p / 32`, at bit `p % 32` of that bank's registers and of the flat pin vectors.

Software never writes output levels directly. It writes a mask to a set register to raise pins and a mask to a clear register to lower them, so two agents can change different pins without a read-modify-write race. The direction register is an ordinary read/write word. The input register returns the pad level through a two-flop synchronizer, whatever the pin's direction. Because of the synchronizer, a read issued right after a pad change still returns the previous level.

The register bus is a single-cycle request with address, write flag and write data. Ready rises exactly one cycle after each request, and read data is valid in that cycle.

Top module: `gpio_bank_regs`

## Requirements
- R1: The register group of bank b starts at byte address 0x10 + 0x28*b. Bit k of that group drives and reads pin 32*b + k of `gpio_out`, `gpio_oe` and `pad_in`. With two banks, bank 0 is at 0x10 and bank 1 is at 0x38.
- R2: After reset, the direction register of every bank reads 0xFFFFFFFF, `gpio_oe` is all zeros, `gpio_out` is all zeros, and `bus_ready` and `bus_rdata` are zero.
- R3: A write to group offset +0x8 (set) raises every pin whose write-data bit is 1 on the next cycle. Pins whose bit is 0 keep their level.
- R4: A write to group offset +0xC (clear) lowers every pin whose write-data bit is 1 on the next cycle. Pins whose bit is 0 keep their level.
- R5: Group offset +0x0 is the direction register. A write loads it, and a read returns it. A direction bit of 1 means the pin is an input, so `gpio_oe` is the inverse of that bit. Output pins and enables change only on writes to the direction, set or clear registers.
- R6: Group offset +0x10 returns the bank's pads through two flip-flops, whether the pins are inputs or outputs. A pad change made before the first of two clock edges is visible to a read whose request is sampled on the following (third) edge. A read sampled on the first edge after the change returns the old level.
- R7: Reads of offsets +0x4, +0x8 and +0xC return the current output levels of the bank. Writes to +0x4 and +0x10 have no effect.
- R8: `bus_ready` is high for exactly the one cycle after each cycle in which `bus_req` is high. In that cycle `bus_rdata` holds the read value. For writes and for addresses outside every group (including offsets +0x14 and above), `bus_rdata` is zero, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the shared window |
| bus_wdata | input | BANK_W | Write data or mask |
| bus_rdata | output | BANK_W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | High one cycle after a request |
| gpio_out | output | NUM_BANKS*BANK_W | Output level per pin |
| gpio_oe | output | NUM_BANKS*BANK_W | Output driver enable per pin |
| pad_in | input | NUM_BANKS*BANK_W | Pad level per pin, asynchronous |

## Verification
Directed masks with overlapping and disjoint bits show that set and clear touch only the bits written as one. Identical masks sent to the two banks expose any decode that leaks into the wrong group. A pad change followed immediately by a read separates a correct two-stage synchronizer from a shorter or missing one. A read after a wait confirms that the level does arrive, even on pins configured as outputs. Random back-to-back traffic over every mapped offset, plus unmapped and misaligned addresses, is compared every cycle against a behavioural model. This catches wrong offsets, writes that should be ignored but are not, and ready pulses that are off by a cycle.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE      = 16,
  parameter int STRIDE    = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_req,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        bus_ready,
  output logic [NUM_BANKS*BANK_W-1:0] gpio_out,
  output logic [NUM_BANKS*BANK_W-1:0] gpio_oe,
  input  logic [NUM_BANKS*BANK_W-1:0] pad_in
);

  logic [BANK_W-1:0] rd_bank [NUM_BANKS];
  logic [BANK_W-1:0] rd_any;
  wire               wr_en = bus_req & bus_wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int GB = BASE + STRIDE * b;
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(GB);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(GB + 4);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(GB + 8);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(GB + 12);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(GB + 16);

    logic [BANK_W-1:0] dir_q, out_q, s1_q, s2_q;

    wire hit_dir = bus_addr == A_DIR;
    wire hit_set = bus_addr == A_SET;
    wire hit_clr = bus_addr == A_CLR;
    wire hit_out = (bus_addr == A_OUT) | hit_set | hit_clr;
    wire hit_in  = bus_addr == A_IN;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= '1;
        out_q <= '0;
        s1_q  <= '0;
        s2_q  <= '0;
      end else begin
        s1_q <= pad_in[b*BANK_W +: BANK_W];
        s2_q <= s1_q;
        if (wr_en && hit_dir) dir_q <= bus_wdata;
        if (wr_en && hit_set) out_q <= out_q | bus_wdata;
        else if (wr_en && hit_clr) out_q <= out_q & ~bus_wdata;
      end
    end

    assign rd_bank[b] = hit_dir ? dir_q :
                        hit_out ? out_q :
                        hit_in  ? s2_q  : '0;

    assign gpio_out[b*BANK_W +: BANK_W] = out_q;
    assign gpio_oe[b*BANK_W +: BANK_W]  = ~dir_q;
  end

  always_comb begin
    rd_any = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_any = rd_any | rd_bank[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_req;
      bus_rdata <= (bus_req && !bus_wr) ? rd_any : '0;
    end
  end

endmodule

module gpio_bank_regs_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE      = 16,
  parameter int STRIDE    = 40
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_req,
  input logic                        bus_wr,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [BANK_W-1:0]           bus_wdata,
  input logic [BANK_W-1:0]           bus_rdata,
  input logic                        bus_ready,
  input logic [NUM_BANKS*BANK_W-1:0] gpio_out,
  input logic [NUM_BANKS*BANK_W-1:0] gpio_oe
);
  localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(BASE + 8);
  localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(BASE + 12);

  assert_ready_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);
  assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ready);
  assert_write_zero_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr) |=> bus_rdata == '0);
  assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == SET0) |=>
      (gpio_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata));
  assert_clear_drives_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == CLR0) |=>
      (gpio_out[BANK_W-1:0] & $past(bus_wdata)) == '0);
  assert_idle_holds_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_wr) |=> ($stable(gpio_out) && $stable(gpio_oe)));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe)
);

// File: tb/gpio_bank_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb_top;
  localparam int NB = 2;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          bus_ready;
  logic [NB*W-1:0] gpio_out, gpio_oe;
  logic [NB*W-1:0] pad_in = '0;

  int checks = 0, failures = 0;
  logic [W-1:0] last_rd;

  gpio_bank_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_in(pad_in)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  logic [W-1:0] m_dir [NB] = '{default: '1};
  logic [W-1:0] m_out [NB] = '{default: '0};
  logic [W-1:0] m_s1  [NB] = '{default: '0};
  logic [W-1:0] m_s2  [NB] = '{default: '0};
  logic [W-1:0] m_rdata = '0;
  logic         m_ready = 1'b0;

  function automatic void decode(input int a, output int bank, output int off);
    bank = -1; off = -1;
    for (int b = 0; b < NB; b++) begin
      int g = 16 + 40 * b;
      if (a >= g && a < g + 20 && ((a - g) % 4) == 0) begin bank = b; off = a - g; end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_dir[b] = '1; m_out[b] = '0; m_s1[b] = '0; m_s2[b] = '0;
      end
      m_rdata = '0; m_ready = 1'b0;
    end else begin
      int bk, of;
      logic [W-1:0] rv;
      decode(int'(bus_addr), bk, of);
      rv = '0;
      if (bk >= 0) begin
        case (of)
          0: rv = m_dir[bk];
          4, 8, 12: rv = m_out[bk];
          16: rv = m_s2[bk];
          default: rv = '0;
        endcase
      end
      m_ready = bus_req;
      m_rdata = (bus_req && !bus_wr) ? rv : '0;
      if (bus_req && bus_wr && bk >= 0) begin
        if (of == 0)  m_dir[bk] = bus_wdata;
        if (of == 8)  m_out[bk] = m_out[bk] | bus_wdata;
        if (of == 12) m_out[bk] = m_out[bk] & ~bus_wdata;
      end
      for (int b = 0; b < NB; b++) begin
        m_s2[b] = m_s1[b];
        m_s1[b] = pad_in[b*W +: W];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NB*W-1:0] eo, ee;
      for (int b = 0; b < NB; b++) begin
        eo[b*W +: W] = m_out[b];
        ee[b*W +: W] = ~m_dir[b];
      end
      chk(bus_ready === m_ready, "R8 ready", 64'(bus_ready), 64'(m_ready));
      chk(bus_rdata === m_rdata, "R8 rdata", 64'(bus_rdata), 64'(m_rdata));
      chk(gpio_out === eo, "R3 gpio_out", gpio_out, eo);
      chk(gpio_oe === ee, "R5 gpio_oe", gpio_oe, ee);
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    last_rd = bus_rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gpio_out === '0, "R2 reset out", gpio_out, 64'h0);
    chk(gpio_oe === '0, "R2 reset oe", gpio_oe, 64'h0);
    chk(bus_ready === 1'b0, "R2 reset ready", 64'(bus_ready), 64'h0);
    do_read(8'h38);
    chk(last_rd === 32'hFFFFFFFF, "R2 R1 bank1 dir reset", 64'(last_rd), 64'hFFFFFFFF);

    do_write(8'h18, 32'h000000F0);
    chk(gpio_out[31:0] === 32'h000000F0, "R3 set", 64'(gpio_out[31:0]), 64'hF0);
    do_write(8'h18, 32'h0000000F);
    chk(gpio_out[31:0] === 32'h000000FF, "R3 set keeps zeros", 64'(gpio_out[31:0]), 64'hFF);
    do_write(8'h1C, 32'h0000003C);
    chk(gpio_out[31:0] === 32'h000000C3, "R4 clear", 64'(gpio_out[31:0]), 64'hC3);

    do_write(8'h40, 32'h80000001);
    chk(gpio_out[63:32] === 32'h80000001, "R1 bank1 set", 64'(gpio_out[63:32]), 64'h80000001);
    chk(gpio_out[31:0] === 32'h000000C3, "R1 bank0 untouched", 64'(gpio_out[31:0]), 64'hC3);

    do_write(8'h10, 32'hFFFF0000);
    chk(gpio_oe[31:0] === 32'h0000FFFF, "R5 oe inverse", 64'(gpio_oe[31:0]), 64'h0000FFFF);
    do_read(8'h10);
    chk(last_rd === 32'hFFFF0000, "R5 dir readback", 64'(last_rd), 64'hFFFF0000);

    do_write(8'h14, 32'hFFFFFFFF);
    chk(gpio_out[31:0] === 32'h000000C3, "R7 write +4 ignored", 64'(gpio_out[31:0]), 64'hC3);
    do_write(8'h48, 32'hFFFFFFFF);
    chk(gpio_out[63:32] === 32'h80000001, "R7 write +10 ignored", 64'(gpio_out[63:32]), 64'h80000001);
    do_read(8'h14);
    chk(last_rd === 32'h000000C3, "R7 read +4", 64'(last_rd), 64'hC3);
    do_read(8'h18);
    chk(last_rd === 32'h000000C3, "R7 read +8", 64'(last_rd), 64'hC3);
    do_read(8'h1C);
    chk(last_rd === 32'h000000C3, "R7 read +C", 64'(last_rd), 64'hC3);

    do_write(8'h24, 32'hFFFFFFFF);
    do_write(8'h11, 32'h00000000);
    chk(gpio_oe[31:0] === 32'h0000FFFF, "R8 unmapped write ignored", 64'(gpio_oe[31:0]), 64'h0000FFFF);
    do_read(8'h24);
    chk(last_rd === 32'h0, "R8 unmapped read zero", 64'(last_rd), 64'h0);

    @(negedge clk);
    pad_in = 64'h12345678_A5A5A5A5;
    repeat (4) @(negedge clk);
    do_read(8'h20);
    chk(last_rd === 32'hA5A5A5A5, "R6 input on output pins", 64'(last_rd), 64'hA5A5A5A5);
    @(negedge clk);
    pad_in[63:32] = 32'hCAFEF00D;
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 8'h48;
    @(negedge clk);
    bus_req = 1'b0;
    chk(bus_rdata === 32'h12345678, "R6 immediate read old", 64'(bus_rdata), 64'h12345678);
    @(negedge clk);
    do_read(8'h48);
    chk(last_rd === 32'hCAFEF00D, "R6 read after sync", 64'(last_rd), 64'hCAFEF00D);

    for (int i = 0; i < 2000; i++) begin
      int pick;
      @(negedge clk);
      pick = int'($urandom_range(0, 13));
      bus_req = $urandom_range(0, 1) == 1;
      bus_wr = $urandom_range(0, 1) == 1;
      bus_wdata = $urandom;
      if (pick < 10) bus_addr = 8'(16 + 40 * (pick / 5) + 4 * (pick % 5));
      else bus_addr = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) pad_in = {$urandom, $urandom};
    end
    @(negedge clk);
    bus_req = 1'b0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule